// File: doc/BRIEF.md
# Progressive 50 Hz Raster Timing Generator

This block produces the complete raster timing for a 15.625 kHz, 50 Hz monitor from one 16 MHz master clock. A horizontal position counter covers the 1024 clock cycles of each 64 µs line. A line counter runs through 256 visible lines and then hands over to a separate blank-line counter for the 56 border and retrace lines. The 312-line frame is not interlaced. From these two positions the block decodes the active-low horizontal and vertical sync pulses, a flag for the active part of each line and a flag for the visible part of the frame.

The block also produces two slow companion signals. One is a character-flash level that completes one period every 16 frames. The other is a one-cycle enable that fires on every fourth master clock and serves as the processor clock strobe. Every output is a register clocked by the master clock and changes on the same edge as the position counters it belongs to. Downstream logic can therefore compare outputs and positions directly.

Top module: `raster_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the start state: `hpos`=0, `vline`=0, `line_active`=1, `frame_active`=1, `hsync_n`=1, `vsync_n`=1, `flash`=0, `cpu_ce`=0. The first line after release is visible line 0, starting at position 0.
- R2: `hpos` advances by one each clock from 0 to 1023 and then returns to 0.
- R3: `vline` changes only on the edge where `hpos` wraps. It then advances by one from 0 to 311 and returns to 0, so visible lines 0..255 are followed by blank lines 256..311.
- R4: `line_active` is 1 exactly when `hpos` is below 768, which is the 48 µs drawing area.
- R5: `frame_active` is 1 exactly when `vline` is below 256.
- R6: `hsync_n` is 0 exactly when `hpos` is in 784..847. The pulse is 64 cycles long and starts 16 cycles after the drawing area ends.
- R7: `vsync_n` is 0 for all of lines 282, 283 and 284, which are three whole lines centred in the blanking region. At all other times it is 1.
- R8: `flash` is 0 for the first 8 frames after reset. It inverts on the edge where `vline` returns to 0 at the start of every eighth following frame, giving a period of 16 frames.
- R9: `cpu_ce` is 1 for one cycle in every four. Counting edges since reset release, it is high when that count modulo 4 equals 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| hpos | output | 10 | Horizontal position within the line, in master clocks |
| vline | output | 9 | Line number within the frame |
| line_active | output | 1 | High during the drawing area of a line |
| frame_active | output | 1 | High during visible lines |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| flash | output | 1 | Character-flash level, period of 16 frames |
| cpu_ce | output | 1 | Processor clock enable, one cycle in four |

## Verification
The densest cycle is the last clock of line 311. In that cycle the horizontal wrap, the line wrap, the switch from the blank counter back to the visible counter and, every eighth frame, the flash inversion all take effect on one edge. Because 1024 is a multiple of four, that edge also coincides with a `cpu_ce` pulse. The bench runs through many frame ends so that this coincidence happens repeatedly. It then forces a second coincidence by pulsing reset in the middle of a frame, at a point where the processor-enable phase is not zero. A per-cycle reference model predicts every output field, and each field is judged against that model on the falling edge.

// File: rtl/raster_sync_pkg.sv
package raster_sync_pkg;

  // True when p lies in the half-open span [s, s+l).
  function automatic logic in_span(input int p, input int s, input int l);
    return (p >= s) && (p < s + l);
  endfunction

endpackage

// File: rtl/rs_hcount.sv
module rs_hcount #(
  parameter int LINE_CYC = 1024,
  localparam int H_W = $clog2(LINE_CYC)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [H_W-1:0] h_q,
  output logic [H_W-1:0] h_nxt,
  output logic           line_end
);
  localparam logic [H_W-1:0] H_LAST = H_W'(LINE_CYC - 1);

  assign line_end = (h_q == H_LAST);

  always_comb begin
    if (rst)           h_nxt = '0;
    else if (line_end) h_nxt = '0;
    else               h_nxt = h_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    h_q <= h_nxt;
  end

  p_h_step_r2: assert property (@(posedge clk) disable iff (rst)
    (h_q != H_LAST) |=> (h_q == $past(h_q) + 1'b1));
  p_h_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (h_q == '0));
endmodule

// File: rtl/rs_vcount.sv
module rs_vcount #(
  parameter int VIS_LINES   = 256,
  parameter int BLANK_LINES = 56,
  localparam int V_W = $clog2(VIS_LINES + BLANK_LINES),
  localparam int A_W = $clog2(VIS_LINES),
  localparam int B_W = $clog2(BLANK_LINES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  output logic [V_W-1:0] v_q,
  output logic [V_W-1:0] v_nxt,
  output logic           frame_end
);
  localparam logic [A_W-1:0] VIS_LAST = A_W'(VIS_LINES - 1);
  localparam logic [B_W-1:0] BLK_LAST = B_W'(BLANK_LINES - 1);

  // Visible-line counter, blank-line counter and the phase that selects one.
  logic [A_W-1:0] vis_q, vis_nxt;
  logic [B_W-1:0] blk_q, blk_nxt;
  logic           in_blank_q, in_blank_nxt;

  assign frame_end = adv && in_blank_q && (blk_q == BLK_LAST);

  always_comb begin
    vis_nxt      = vis_q;
    blk_nxt      = blk_q;
    in_blank_nxt = in_blank_q;
    if (rst) begin
      vis_nxt      = '0;
      blk_nxt      = '0;
      in_blank_nxt = 1'b0;
    end else if (adv) begin
      if (!in_blank_q) begin
        if (vis_q == VIS_LAST) begin
          vis_nxt      = '0;
          in_blank_nxt = 1'b1;
        end else begin
          vis_nxt = vis_q + 1'b1;
        end
      end else begin
        if (blk_q == BLK_LAST) begin
          blk_nxt      = '0;
          in_blank_nxt = 1'b0;
        end else begin
          blk_nxt = blk_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    vis_q      <= vis_nxt;
    blk_q      <= blk_nxt;
    in_blank_q <= in_blank_nxt;
  end

  assign v_q   = in_blank_q   ? V_W'(VIS_LINES + int'(blk_q))   : V_W'(vis_q);
  assign v_nxt = in_blank_nxt ? V_W'(VIS_LINES + int'(blk_nxt)) : V_W'(vis_nxt);

  p_v_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(v_q));
  p_v_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (v_q == '0));
  p_blank_idle_r3: assert property (@(posedge clk) disable iff (rst)
    in_blank_q |-> (vis_q == '0));
endmodule

// File: rtl/rs_flash.sv
module rs_flash #(
  parameter int FLASH_DIV = 16,
  localparam int HALF = FLASH_DIV / 2,
  localparam int F_W = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  output logic flash
);
  localparam logic [F_W-1:0] F_LAST = F_W'(HALF - 1);

  logic [F_W-1:0] fcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      flash  <= 1'b0;
    end else if (frame_end) begin
      if (fcnt_q == F_LAST) begin
        fcnt_q <= '0;
        flash  <= ~flash;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  p_flash_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(flash));
endmodule

// File: rtl/rs_cpu_ce.sv
module rs_cpu_ce #(
  parameter int CPU_DIV = 4,
  localparam int C_W = (CPU_DIV > 2) ? $clog2(CPU_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic ce
);
  localparam logic [C_W-1:0] C_LAST = C_W'(CPU_DIV - 1);

  logic [C_W-1:0] c_q, c_nxt;

  always_comb begin
    if (rst)                c_nxt = '0;
    else if (c_q == C_LAST) c_nxt = '0;
    else                    c_nxt = c_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    c_q <= c_nxt;
    if (rst) ce <= 1'b0;
    else     ce <= (c_nxt == C_LAST);
  end

  p_ce_single_r9: assert property (@(posedge clk) disable iff (rst)
    ce |=> !ce);
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
  parameter int LINE_CYC    = 1024,
  parameter int ACT_CYC     = 768,
  parameter int HS_GAP      = 16,
  parameter int HS_LEN      = 64,
  parameter int VIS_LINES   = 256,
  parameter int BLANK_LINES = 56,
  parameter int VS_LEN      = 3,
  parameter int FLASH_DIV   = 16,
  parameter int CPU_DIV     = 4,
  localparam int H_W = $clog2(LINE_CYC),
  localparam int V_W = $clog2(VIS_LINES + BLANK_LINES)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [H_W-1:0] hpos,
  output logic [V_W-1:0] vline,
  output logic           line_active,
  output logic           frame_active,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           flash,
  output logic           cpu_ce
);
  import raster_sync_pkg::*;

  localparam int HS_START = ACT_CYC + HS_GAP;
  localparam int VS_START = VIS_LINES + (BLANK_LINES - VS_LEN) / 2;

  logic [H_W-1:0] h_nxt;
  logic [V_W-1:0] v_nxt;
  logic           line_end, frame_end;

  rs_hcount #(.LINE_CYC(LINE_CYC)) u_h (
    .clk(clk), .rst(rst), .h_q(hpos), .h_nxt(h_nxt), .line_end(line_end));

  rs_vcount #(.VIS_LINES(VIS_LINES), .BLANK_LINES(BLANK_LINES)) u_v (
    .clk(clk), .rst(rst), .adv(line_end), .v_q(vline), .v_nxt(v_nxt),
    .frame_end(frame_end));

  rs_flash #(.FLASH_DIV(FLASH_DIV)) u_fl (
    .clk(clk), .rst(rst), .frame_end(frame_end), .flash(flash));

  rs_cpu_ce #(.CPU_DIV(CPU_DIV)) u_ce (
    .clk(clk), .rst(rst), .ce(cpu_ce));

  // Decode from the next position so the registered flags line up with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_active  <= 1'b1;
      frame_active <= 1'b1;
      hsync_n      <= 1'b1;
      vsync_n      <= 1'b1;
    end else begin
      line_active  <= int'(h_nxt) < ACT_CYC;
      frame_active <= int'(v_nxt) < VIS_LINES;
      hsync_n      <= !in_span(int'(h_nxt), HS_START, HS_LEN);
      vsync_n      <= !in_span(int'(v_nxt), VS_START, VS_LEN);
    end
  end

  p_act_r4: assert property (@(posedge clk) disable iff (rst)
    line_active == (int'(hpos) < ACT_CYC));
  p_vis_r5: assert property (@(posedge clk) disable iff (rst)
    frame_active == (int'(vline) < VIS_LINES));
  p_hs_blank_r6: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !line_active);
  p_vs_blank_r7: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> !frame_active);
  p_vs_line_r7: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(vsync_n));
endmodule

// File: tb/raster_sync_gen_tb_top.sv
module raster_sync_gen_tb_top;
  localparam int L   = 64;
  localparam int ACT = 48;
  localparam int HG  = 4;
  localparam int HL  = 8;
  localparam int VIS = 16;
  localparam int BLK = 8;
  localparam int VL  = 2;
  localparam int FD  = 16;
  localparam int CD  = 4;
  localparam int F   = VIS + BLK;
  localparam int VSS = VIS + (BLK - VL) / 2;
  localparam int H_W = $clog2(L);
  localparam int V_W = $clog2(F);

  typedef struct {
    bit in_rst;
    int h, v;
    bit la, fa, hs, vs, fl, ce;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [H_W-1:0] hpos;
  logic [V_W-1:0] vline;
  logic line_active, frame_active, hsync_n, vsync_n, flash, cpu_ce;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit ended  = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  raster_sync_gen #(
    .LINE_CYC(L), .ACT_CYC(ACT), .HS_GAP(HG), .HS_LEN(HL),
    .VIS_LINES(VIS), .BLANK_LINES(BLK), .VS_LEN(VL),
    .FLASH_DIV(FD), .CPU_DIV(CD)
  ) dut_i (
    .clk(clk), .rst(rst), .hpos(hpos), .vline(vline),
    .line_active(line_active), .frame_active(frame_active),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .flash(flash), .cpu_ce(cpu_ce)
  );

  // Expected outputs after k edges since reset release, from the requirements.
  function automatic exp_t model(input int k, input bit r);
    exp_t e;
    int line_idx, frame;
    line_idx = k / L;
    frame    = line_idx / F;
    e.in_rst = r;
    e.h  = k % L;
    e.v  = line_idx % F;
    e.la = e.h < ACT;
    e.fa = e.v < VIS;
    e.hs = !((e.h >= ACT + HG) && (e.h < ACT + HG + HL));
    e.vs = !((e.v >= VSS) && (e.v < VSS + VL));
    e.fl = ((frame / (FD / 2)) % 2) == 1;
    e.ce = (k % CD) == CD - 1;
    return e;
  endfunction

  task automatic push_exp(input int k, input bit r);
    sb_q.push_back(model(k, r));
  endtask

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (hpos=%0d vline=%0d)",
               tag, act, expv, hpos, vline);
    end
  endtask

  // Driver side: one expected item per clock edge.
  always @(posedge clk) begin
    if (!ended) begin
      if (rst) n = 0;
      else     n = n + 1;
      push_exp(n, rst);
    end
  end

  // Monitor side: compare on the falling edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      if (e.in_rst) begin
        chk("R1 hpos", int'(hpos), 0);
        chk("R1 vline", int'(vline), 0);
        chk("R1 line_active", int'(line_active), 1);
        chk("R1 frame_active", int'(frame_active), 1);
        chk("R1 hsync_n", int'(hsync_n), 1);
        chk("R1 vsync_n", int'(vsync_n), 1);
        chk("R1 flash", int'(flash), 0);
        chk("R1 cpu_ce", int'(cpu_ce), 0);
      end else begin
        chk("R2 hpos", int'(hpos), e.h);
        chk("R3 vline", int'(vline), e.v);
        chk("R4 line_active", int'(line_active), int'(e.la));
        chk("R5 frame_active", int'(frame_active), int'(e.fa));
        chk("R6 hsync_n", int'(hsync_n), int'(e.hs));
        chk("R7 vsync_n", int'(vsync_n), int'(e.vs));
        chk("R8 flash", int'(flash), int'(e.fl));
        chk("R9 cpu_ce", int'(cpu_ce), int'(e.ce));
      end
    end
  end

  task automatic finish_run;
    ended = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // Run into frame 10, then reset mid-line off the enable phase (R1, R9).
    repeat (10 * F * L + 5 * L + 21) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // Seventeen more frames: two flash inversions and many frame ends (R8).
    repeat (17 * F * L + 10) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule